// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns one parallel pixel word per pixel clock into three serial data lanes plus a framing clock lane. A pixel word is eighteen colour bits (six each of red, green and blue) together with line sync, frame sync and data enable. Each lane sends seven bits per pixel period. The block runs entirely on a bit clock at seven times the pixel rate. The pixel clock arrives as an ordinary input, and the block samples it through a synchronizer.

A strap input picks which pixel clock edge captures the word. A watchdog on the sampled pixel clock forces every lane low when that clock goes quiet. Normal output returns only after two full pixel periods of clean clock, and power-down does not have to be cycled. An active-low power-down input holds the whole block in reset and drops the drive enable, so the pad drivers go to high impedance. A captured word goes out in the pixel period after the one in which it was captured. The downstream pad ring uses the clock lane's rising edge to find slot 0.

Top module: `pixlink_serializer`

## Requirements
- R1: The block captures every input bit (red, green, blue, line sync, frame sync, data enable) on each selected pixel clock edge, and sends each captured word without loss.
- R2: Lane 0 carries red[5:0] then green[0]. Lane 1 carries green[5:1] then blue[1:0]. Lane 2 carries blue[5:2], then line sync, frame sync and data enable, in that order.
- R3: Each lane sends seven slots per pixel period, one slot per bit clock. Slot 0 holds the lowest-numbered bit listed for that lane in R2, and the slots follow in ascending order.
- R4: While the link is up, the clock lane is high for four bit times (slots 0 to 3) and low for three (slots 4 to 6). Its rising edge marks slot 0 of the data lanes.
- R5: With edge_sel_i high, words are captured on the rising pixel clock edge. With it low, they are captured on the falling edge.
- R6: When 16 consecutive bit clocks pass with no pixel clock edge, all four lanes are driven low and drive_en_o stays high.
- R7: While pdn_ni is low, the block is held in reset, drive_en_o is low and all four lanes read 0.
- R8: After the pixel clock restarts, or after pdn_ni or rst_ni is released, the lanes stay low until two full pixel periods of clean clock have passed. Normal serial output then resumes with no power-down cycle needed.
- R9: A pixel clock phase that lasts fewer than 16 bit clocks never drops the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdn_ni | input | 1 | Active-low power-down; holds the block in reset |
| pix_clk_i | input | 1 | Pixel clock, sampled by clk_i |
| edge_sel_i | input | 1 | Capture edge: 1 rising, 0 falling |
| red_i | input | 6 | Red colour bits |
| green_i | input | 6 | Green colour bits |
| blue_i | input | 6 | Blue colour bits |
| hsync_i | input | 1 | Line sync |
| vsync_i | input | 1 | Frame sync |
| den_i | input | 1 | Data enable |
| data_lane_o | output | 3 | Serial data lanes 0 to 2 |
| clk_lane_o | output | 1 | Framing clock lane |
| drive_en_o | output | 1 | Pad drive enable; low means high impedance |

## Verification
Several fixed words are sent, each held steady across several pixel periods:
- All zeros and all ones expose stuck slots.
- Alternating bits catch slot order reversed within a lane.
- A red-only word and a control-only word show lane mapping errors, because each lights up exactly one lane region.

A second pattern changes the input word in the middle of each pixel period. One value is present at the rising edge and another at the falling edge, so the serialized result shows which edge was used. Further tests cover a stopped clock, a restart, a stretched low phase that stays below the timeout, and a power-down pulse. In each case the bench checks whether the lanes go quiet or keep their pattern.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;
  localparam int unsigned DEF_COLOR_W = 6;
  localparam int unsigned DEF_SLOTS   = 7;

  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_state_e;
endpackage

// File: rtl/pixlink_edge_sync.sv
module pixlink_edge_sync #(
  parameter int W = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pix_clk_i,
  input  logic         edge_sel_i,
  input  logic [W-1:0] data_i,
  output logic         strobe_o,
  output logic         any_edge_o,
  output logic [W-1:0] word_o
);
  // pc_q[0], pc_q[1]: synchronizer; pc_q[2]: history for edge detect
  logic [2:0]   pc_q;
  logic [W-1:0] d1_q, d2_q;
  logic         rise, fall;

  assign rise       = pc_q[1] & ~pc_q[2];
  assign fall       = ~pc_q[1] & pc_q[2];
  assign strobe_o   = edge_sel_i ? rise : fall;
  assign any_edge_o = pc_q[1] ^ pc_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      word_o <= '0;
    end else begin
      pc_q <= {pc_q[1:0], pix_clk_i};
      // data follows the same delay as the clock samples
      d1_q <= data_i;
      d2_q <= d1_q;
      if (strobe_o) word_o <= d2_q;
    end
  end
endmodule

// File: rtl/pixlink_clk_monitor.sv
module pixlink_clk_monitor
  import pixlink_pkg::*;
#(
  parameter int LOSS_LIMIT   = 16,
  parameter int GOOD_PERIODS = 2,
  localparam int IW = $clog2(LOSS_LIMIT + 1),
  localparam int GW = $clog2(GOOD_PERIODS + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic any_edge_i,
  output logic link_up_o
);
  localparam logic [IW-1:0] IDLE_LAST = IW'(LOSS_LIMIT - 1);
  localparam logic [IW-1:0] IDLE_SAT  = IW'(LOSS_LIMIT);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_PERIODS);

  logic [IW-1:0] idle_q;
  logic [GW-1:0] good_q;
  link_state_e   state_q;
  logic          timeout;

  assign timeout   = !any_edge_i && (idle_q == IDLE_LAST);
  assign link_up_o = (state_q == LINK_UP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (any_edge_i) begin
      idle_q <= '0;
    end else if (idle_q != IDLE_SAT) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_DOWN;
      good_q  <= '0;
    end else begin
      unique case (state_q)
        LINK_UP: begin
          if (timeout) begin
            state_q <= LINK_DOWN;
            good_q  <= '0;
          end
        end
        default: begin
          if (timeout) begin
            good_q <= '0;
          end else if (strobe_i) begin
            // third clean strobe closes two full periods
            if (good_q == GOOD_LAST) begin
              state_q <= LINK_UP;
              good_q  <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pixlink_lane_ser.sv
module pixlink_lane_ser #(
  parameter int SLOTS = 7,
  parameter int LANES = 3,
  localparam int WORD_W = SLOTS * LANES,
  localparam int SW     = $clog2(SLOTS),
  localparam int HIGH_N = (SLOTS + 1) / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LANES-1:0]  lane_bits_o,
  output logic              frame_bit_o
);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] SLOT_HIGH = SW'(HIGH_N);

  logic [SW-1:0]     slot_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sh_q   <= '0;
    end else if (strobe_i) begin
      // word captured at the previous strobe starts now
      slot_q <= '0;
      sh_q   <= word_i;
    end else begin
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] lane_word;
    assign lane_word      = sh_q[l*SLOTS +: SLOTS];
    assign lane_bits_o[l] = lane_word[slot_q];
  end

  assign frame_bit_o = (slot_q < SLOT_HIGH);
endmodule

// File: rtl/pixlink_serializer.sv
module pixlink_serializer
  import pixlink_pkg::*;
#(
  parameter int COLOR_W      = DEF_COLOR_W,
  parameter int SLOTS        = DEF_SLOTS,
  parameter int LOSS_LIMIT   = 16,
  parameter int GOOD_PERIODS = 2,
  localparam int WORD_W = 3 * COLOR_W + 3,
  localparam int LANES  = WORD_W / SLOTS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pdn_ni,
  input  logic               pix_clk_i,
  input  logic               edge_sel_i,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               den_i,
  output logic [LANES-1:0]   data_lane_o,
  output logic               clk_lane_o,
  output logic               drive_en_o
);
  logic              core_rst_n;
  logic [WORD_W-1:0] pix_word, cap_word;
  logic              strobe, any_edge, link_up;
  logic [LANES-1:0]  lane_bits;
  logic              frame_bit;
  logic              drive_q;

  // power-down acts as a second asynchronous reset
  assign core_rst_n = rst_ni & pdn_ni;
  assign pix_word   = {den_i, vsync_i, hsync_i, blue_i, green_i, red_i};

  pixlink_edge_sync #(.W(WORD_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (core_rst_n),
    .pix_clk_i  (pix_clk_i),
    .edge_sel_i (edge_sel_i),
    .data_i     (pix_word),
    .strobe_o   (strobe),
    .any_edge_o (any_edge),
    .word_o     (cap_word)
  );

  pixlink_clk_monitor #(
    .LOSS_LIMIT   (LOSS_LIMIT),
    .GOOD_PERIODS (GOOD_PERIODS)
  ) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (core_rst_n),
    .strobe_i   (strobe),
    .any_edge_i (any_edge),
    .link_up_o  (link_up)
  );

  pixlink_lane_ser #(.SLOTS(SLOTS), .LANES(LANES)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (core_rst_n),
    .strobe_i    (strobe),
    .word_i      (cap_word),
    .lane_bits_o (lane_bits),
    .frame_bit_o (frame_bit)
  );

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) drive_q <= 1'b0;
    else             drive_q <= 1'b1;
  end

  assign drive_en_o  = drive_q;
  assign data_lane_o = (drive_q && link_up) ? lane_bits : '0;
  assign clk_lane_o  = drive_q && link_up && frame_bit;
endmodule

// File: rtl/pixlink_serializer_chk.sv
module pixlink_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pdn_ni,
  input logic       pix_clk_i,
  input logic [2:0] data_lane_o,
  input logic       clk_lane_o,
  input logic       drive_en_o
);
  logic [4:0] idle_q;
  logic       pix_prev_q;
  logic [2:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q     <= '0;
      pix_prev_q <= 1'b0;
    end else begin
      pix_prev_q <= pix_clk_i;
      if (pix_clk_i != pix_prev_q) idle_q <= '0;
      else if (idle_q != 5'd31)    idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_run_q <= '0;
    else if (!pdn_ni)    hi_run_q <= '0;
    else if (clk_lane_o) hi_run_q <= (hi_run_q == 3'd7) ? hi_run_q : hi_run_q + 1'b1;
    else                 hi_run_q <= '0;
  end

  // R7: power-down releases the pads and quiets every lane
  a_r7_pdn_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |-> (!drive_en_o && data_lane_o == 3'b000 && !clk_lane_o));

  // R7: lanes never carry data while the pads are released
  a_r7_quiet_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_o |-> (data_lane_o == 3'b000 && !clk_lane_o));

  // R4: clock lane high phase is at most four bit times
  a_r4_high_run: assert property (@(posedge clk_i) disable iff (!rst_ni || !pdn_ni)
    clk_lane_o |-> (hi_run_q < 3'd4));

  // R6: a long quiet pixel clock forces all lanes low
  a_r6_lost_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !pdn_ni)
    (idle_q >= 5'd24) |-> (data_lane_o == 3'b000 && !clk_lane_o));

  // R7: drive enable only rises once power-down is released
  a_r7_enable_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_en_o) |-> pdn_ni);
endmodule

bind pixlink_serializer pixlink_serializer_chk u_chk (.*);

// File: tb/tb_pixlink_serializer.sv
`timescale 1ns/1ps
module tb_pixlink_serializer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pdn_ni = 1'b1;
  logic       pix_clk = 1'b0;
  logic       edge_sel = 1'b0;
  logic [5:0] red = '0, green = '0, blue = '0;
  logic       hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic [2:0] data_lane;
  logic       clk_lane, drive_en;

  int total = 0;
  int bad = 0;

  logic       rec_clk [0:20];
  logic [2:0] rec_dat [0:20];
  int         rec_idx = 0;
  bit         rec_on = 1'b0;

  // word packing: bits 5:0 red, 11:6 green, 17:12 blue, 18 hsync, 19 vsync, 20 den
  localparam logic [20:0] VEC [7] = '{
    21'h000000, 21'h1FFFFF, 21'h155555, 21'h0AAAAA,
    21'h00003F, 21'h1C0000, 21'h0FC0C1
  };

  always #5 clk = ~clk;

  pixlink_serializer dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pdn_ni      (pdn_ni),
    .pix_clk_i   (pix_clk),
    .edge_sel_i  (edge_sel),
    .red_i       (red),
    .green_i     (green),
    .blue_i      (blue),
    .hsync_i     (hsync),
    .vsync_i     (vsync),
    .den_i       (den),
    .data_lane_o (data_lane),
    .clk_lane_o  (clk_lane),
    .drive_en_o  (drive_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rec_on && rec_idx < 21) begin
      rec_clk[rec_idx] = clk_lane;
      rec_dat[rec_idx] = data_lane;
      rec_idx++;
    end
  endtask

  task automatic drive_word(input logic [20:0] w);
    {den, vsync, hsync, blue, green, red} = w;
  endtask

  task automatic pix_period(input logic [20:0] a, input logic [20:0] b, input int low_extra);
    tick(); pix_clk = 1'b1; drive_word(a);
    repeat (3) tick();
    pix_clk = 1'b0; drive_word(b);
    repeat (3 + low_extra) tick();
  endtask

  // R2 lane mapping: lane l slot s carries word bit 7*l+s
  function automatic logic [6:0] exp_lane(input logic [20:0] w, input int l);
    logic [6:0] v;
    for (int s = 0; s < 7; s++) v[s] = w[7*l + s];
    return v;
  endfunction

  task automatic run_check(input logic [20:0] a, input logic [20:0] b,
                           input logic [20:0] exp, input string req);
    int k;
    logic [6:0] got_l, got_c;
    repeat (3) pix_period(a, b, 0);
    rec_idx = 0; rec_on = 1'b1;
    repeat (3) pix_period(a, b, 0);
    rec_on = 1'b0;
    k = -1;
    for (int i = 1; i <= 8; i++)
      if (k < 0 && rec_clk[i] && !rec_clk[i-1]) k = i;
    chk(k >= 0, {req, " R4 clock lane rise"}, 32'(k), 32'd1);
    if (k >= 0) begin
      for (int l = 0; l < 3; l++) begin
        for (int s = 0; s < 7; s++) got_l[s] = rec_dat[k+s][l];
        chk(got_l == exp_lane(exp, l), {req, " R1 R2 R3 lane"}, 32'(got_l), 32'(exp_lane(exp, l)));
      end
      for (int s = 0; s < 7; s++) got_c[s] = rec_clk[k+s];
      chk(got_c == 7'b0001111, {req, " R4 clock pattern"}, 32'(got_c), 32'h0F);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_up();
  end

  initial begin
    int quiet;
    repeat (3) tick();
    chk(!drive_en && data_lane == 3'b000 && !clk_lane, "R7 reset state",
        32'({drive_en, clk_lane, data_lane}), 32'h0);
    rst_ni = 1'b1;
    repeat (6) tick();
    chk(drive_en && data_lane == 3'b000 && !clk_lane, "R6 no pixel clock after reset",
        32'({drive_en, clk_lane, data_lane}), 32'h10);

    // main table walk, falling-edge capture
    for (int v = 0; v < 7; v++) run_check(VEC[v], VEC[v], VEC[v], $sformatf("vec%0d", v));

    // R5: strobe edge select, word differs between high and low phase
    edge_sel = 1'b1; pdn_ni = 1'b0; repeat (3) tick(); pdn_ni = 1'b1;
    run_check(21'h123456, 21'h0EDCBA, 21'h123456, "R5 rising");
    edge_sel = 1'b0; pdn_ni = 1'b0; repeat (3) tick(); pdn_ni = 1'b1;
    run_check(21'h123456, 21'h0EDCBA, 21'h0EDCBA, "R5 falling");

    // R9: stretched low phase below the loss limit keeps the link
    rec_idx = 0; rec_on = 1'b1;
    pix_period(21'h1FFFFF, 21'h1FFFFF, 7);
    rec_on = 1'b0;
    quiet = 0;
    for (int i = 0; i < 14; i++) quiet += int'(rec_clk[i]);
    chk(quiet == 8, "R9 stretched phase keeps clock lane", 32'(quiet), 32'd8);
    run_check(21'h1FFFFF, 21'h1FFFFF, 21'h1FFFFF, "R9 after stretch");

    // R6: pixel clock stops
    drive_word(21'h1FFFFF);
    repeat (25) tick();
    quiet = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (data_lane != 3'b000 || clk_lane || !drive_en) quiet++;
    end
    chk(quiet == 0, "R6 lost clock forces lanes low", 32'(quiet), 32'd0);

    // R8: restart, stays low early, then recovers without power-down
    rec_idx = 0; rec_on = 1'b1;
    pix_period(21'h1FFFFF, 21'h1FFFFF, 0);
    pix_period(21'h1FFFFF, 21'h1FFFFF, 0);
    rec_on = 1'b0;
    quiet = 0;
    for (int i = 0; i < 9; i++) if (rec_dat[i] != 3'b000 || rec_clk[i]) quiet++;
    chk(quiet == 0, "R8 held low after restart", 32'(quiet), 32'd0);
    run_check(21'h0AAAAA, 21'h0AAAAA, 21'h0AAAAA, "R8 recovered");

    // R7: power-down while running
    pix_clk = 1'b1; pdn_ni = 1'b0;
    repeat (2) tick();
    chk(!drive_en && data_lane == 3'b000 && !clk_lane, "R7 power-down releases pads",
        32'({drive_en, clk_lane, data_lane}), 32'h0);
    pix_clk = 1'b0; pdn_ni = 1'b1;
    repeat (2) tick();
    chk(drive_en && data_lane == 3'b000 && !clk_lane, "R8 low after power-down release",
        32'({drive_en, clk_lane, data_lane}), 32'h10);
    run_check(21'h155555, 21'h155555, 21'h155555, "R8 after power-down");

    finish_up();
  end
endmodule